// File: doc/BRIEF.md
# USB Suspend and Wakeup Controller

This block sits beside a full-speed USB device core and decides when the bus has gone quiet long enough for the device to suspend, and when renewed bus traffic should wake it. It takes a bus-activity strobe and a USB-reset strobe from the line-side clock domain and brings both into the local clock domain through two-flop synchronizers. An idle counter, running on a known reference clock, measures the time since the last traffic. It emits a one-cycle suspend request when the count that equals 3 ms runs out.

Firmware answers the request by asserting a force-suspend control and, if it chooses, a low-power mode bit. While suspended, the block ignores idle time and watches for activity. The first activity raises a one-cycle wakeup event, raises a wakeup line for the rest of the chip, and clears the low-power bit in the same cycle without waiting for firmware. The wakeup line stays up until firmware reports, through a resume-complete strobe, that the resume sequence is over. Idle timing then starts again from zero.

Top module: `usw_top`

## Requirements
- R1: `bus_act` and `usb_rst` each pass through two synchronizer flops. With the block armed and not suspended, a one-cycle `bus_act` pulse makes `susp_req` high in the cycle that follows the (IDLE_CYCLES+3)th rising edge, counted from the first edge that samples the pulse.
- R2: After `rst`, no `susp_req` is produced until a `usb_rst` pulse has been seen. A `usb_rst` pulse arms the idle check and starts the count with the same timing as a `bus_act` pulse under R1.
- R3: `susp_req` is a single-cycle pulse. After it fires, it does not fire again until new activity, a USB reset or a resume reloads the counter.
- R4: Activity that arrives before the count expires restarts the count. Only the timing of the last pulse under R1 applies.
- R5: From the edge that samples `force_susp` high, the block holds a suspended state until the edge that samples `resume_done`. During that state no `susp_req` is produced. After `resume_done` the count restarts, and `susp_req` appears after the (IDLE_CYCLES+1)th edge, counted from the edge that samples `resume_done`.
- R6: While suspended, a `bus_act` pulse produces a one-cycle `wake_evt` after the third edge from the sampling edge. `wake_line` goes high at that same edge and stays high until the edge that samples `resume_done`.
- R7: `lp_mode` is set by a `lp_set` pulse. While suspended, it drops in the cycle in which the synchronized activity reaches the wake logic, which is after the second edge and one cycle before `wake_evt`. It then stays low.
- R8: Activity while not suspended produces no `wake_evt` and leaves `lp_mode` unchanged.
- R9: Only one `wake_evt` is produced per suspension. Further activity before `resume_done` produces no event and leaves `wake_line` high.
- R10: After `rst`, `susp_req`, `wake_evt`, `wake_line` and `lp_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the idle count |
| rst | input | 1 | Synchronous active-high reset |
| bus_act | input | 1 | Bus-traffic strobe from the line domain |
| usb_rst | input | 1 | USB bus-reset strobe from the line domain |
| force_susp | input | 1 | Firmware request to enter the suspended state |
| resume_done | input | 1 | Firmware strobe marking the end of resume |
| lp_set | input | 1 | Firmware strobe setting the low-power bit |
| susp_req | output | 1 | One-cycle pulse when the bus has been idle for 3 ms |
| wake_evt | output | 1 | One-cycle pulse on the first activity while suspended |
| wake_line | output | 1 | Level wakeup notification, held until resume ends |
| lp_mode | output | 1 | Low-power mode bit |

## Verification
Every result has a fixed latency, counted in rising edges from the edge that first samples the stimulus. An activity or USB-reset pulse yields a suspend request after IDLE_CYCLES+3 edges. A resume strobe yields one after IDLE_CYCLES+1 edges. A wakeup event is due after 3 edges, and the low-power bit drops after 2. The driver reads a free-running edge counter when it applies a stimulus, adds the latency, and queues the expected event with that edge number. The monitor samples on falling edges, away from the active edge, and compares each pulse it sees with the head of the queue. Any pulse that arrives with nothing queued fails, as does any expected event still queued at the end, so both missing and extra events are caught.

// File: rtl/usw_pkg.sv
package usw_pkg;
  // number of flops in each crossing chain
  localparam int unsigned SYNC_DEPTH = 2;

  // count for 3 ms at 48 MHz
  localparam int unsigned DEF_IDLE_CYCLES = 144000;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/usw_sync.sv
module usw_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = usw_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/usw_idle_timer.sv
module usw_idle_timer #(
  parameter int unsigned IDLE_CYCLES = usw_pkg::DEF_IDLE_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic usb_rst,
  input  logic en,
  output logic susp_req
);
  localparam int unsigned CW = usw_pkg::cnt_width(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          fired;
  logic          armed;
  logic          reload;

  // any traffic, a bus reset, suspension or a disarmed state restarts the count
  assign reload = act | usb_rst | ~en | ~armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      fired    <= 1'b0;
      armed    <= 1'b0;
      susp_req <= 1'b0;
    end else begin
      susp_req <= 1'b0;
      if (usb_rst) armed <= 1'b1;
      if (reload) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (cnt == LAST) begin
          susp_req <= 1'b1;
          fired    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    susp_req |=> !susp_req); // R3

  AST_NO_REQ_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !susp_req); // R5

  AST_NO_REQ_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !$past(armed) |-> !susp_req); // R2
endmodule

// File: rtl/usw_wake_ctl.sv
module usw_wake_ctl (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic force_susp,
  input  logic resume_done,
  input  logic lp_set,
  output logic suspended,
  output logic wake_evt,
  output logic wake_line,
  output logic lp_mode
);
  logic lp_q;
  logic wake_hit;

  assign wake_hit = suspended & act & ~resume_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      suspended <= 1'b0;
      wake_evt  <= 1'b0;
      wake_line <= 1'b0;
    end else begin
      wake_evt <= 1'b0;
      if (resume_done) begin
        suspended <= 1'b0;
        wake_line <= 1'b0;
      end else begin
        if (force_susp) suspended <= 1'b1;
        if (wake_hit && !wake_line) begin
          wake_evt  <= 1'b1;
          wake_line <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           lp_q <= 1'b0;
    else if (wake_hit) lp_q <= 1'b0;
    else if (lp_set)   lp_q <= 1'b1;
  end

  // same-cycle bypass: the bit drops as soon as the wake condition is seen
  assign lp_mode = lp_q & ~wake_hit;

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wake_line && !resume_done |=> wake_line); // R6

  AST_LINE_DROPS: assert property (@(posedge clk) disable iff (rst)
    resume_done |=> !wake_line); // R6

  AST_ONE_WAKE: assert property (@(posedge clk) disable iff (rst)
    wake_line && !resume_done |=> !wake_evt); // R9

  AST_LP_LOW_AT_WAKE: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> !lp_mode); // R7

  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (rst)
    !suspended |=> !wake_evt); // R8
endmodule

// File: rtl/usw_top.sv
module usw_top #(
  parameter int unsigned IDLE_CYCLES = usw_pkg::DEF_IDLE_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_act,
  input  logic usb_rst,
  input  logic force_susp,
  input  logic resume_done,
  input  logic lp_set,
  output logic susp_req,
  output logic wake_evt,
  output logic wake_line,
  output logic lp_mode
);
  logic [1:0] raw_in;
  logic [1:0] sync_in;
  logic       act_s;
  logic       urst_s;
  logic       suspended;

  assign raw_in = {usb_rst, bus_act};

  usw_sync #(.WIDTH(2), .DEPTH(usw_pkg::SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign act_s  = sync_in[0];
  assign urst_s = sync_in[1];

  usw_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .act      (act_s),
    .usb_rst  (urst_s),
    .en       (~suspended),
    .susp_req (susp_req)
  );

  usw_wake_ctl u_wake (
    .clk         (clk),
    .rst         (rst),
    .act         (act_s),
    .force_susp  (force_susp),
    .resume_done (resume_done),
    .lp_set      (lp_set),
    .suspended   (suspended),
    .wake_evt    (wake_evt),
    .wake_line   (wake_line),
    .lp_mode     (lp_mode)
  );

  AST_EVENTS_APART: assert property (@(posedge clk) disable iff (rst)
    !(susp_req && wake_evt)); // R5
endmodule

// File: tb/sim_usw_top.sv
module sim_usw_top;
  localparam int unsigned L = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_act = 1'b0, usb_rst = 1'b0, force_susp = 1'b0;
  logic resume_done = 1'b0, lp_set = 1'b0;
  logic susp_req, wake_evt, wake_line, lp_mode;

  always #2 clk = ~clk;

  usw_top #(.IDLE_CYCLES(L)) u0 (
    .clk(clk), .rst(rst), .bus_act(bus_act), .usb_rst(usb_rst),
    .force_susp(force_susp), .resume_done(resume_done), .lp_set(lp_set),
    .susp_req(susp_req), .wake_evt(wake_evt), .wake_line(wake_line),
    .lp_mode(lp_mode)
  );

  typedef struct {
    int    kind;   // 0 = suspend request, 1 = wake event
    int    due;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int due, input string req);
    exp_t e;
    e.kind = kind; e.due = due; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic monitor_ev(input int kind);
    if (exp_q.size() == 0) begin
      chk(kind ? "R8/R9 unexpected wake_evt" : "R2/R3/R5 unexpected susp_req",
          1'b0, cyc, -1);
    end else begin
      exp_t e = exp_q.pop_front();
      chk({e.req, " kind"}, e.kind == kind, kind, e.kind);
      chk({e.req, " cycle"}, e.due == cyc, cyc, e.due);
    end
  endtask

  // monitor: samples on falling edges
  always @(negedge clk) begin
    if (!rst) begin
      if (susp_req) monitor_ev(0);
      if (wake_evt) monitor_ev(1);
    end
  end

  // one-cycle pulse on a strobe, returns edge count at drive time
  task automatic pulse_act(output int at);
    @(negedge clk); at = cyc; bus_act = 1'b1;
    @(negedge clk); bus_act = 1'b0;
  endtask

  task automatic pulse_urst(output int at);
    @(negedge clk); at = cyc; usb_rst = 1'b1;
    @(negedge clk); usb_rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (cycle %0d)", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int t, t2, w, m;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 susp_req", susp_req == 1'b0, susp_req, 0);
    chk("R10 wake_evt", wake_evt == 1'b0, wake_evt, 0);
    chk("R10 wake_line", wake_line == 1'b0, wake_line, 0);
    chk("R10 lp_mode", lp_mode == 1'b0, lp_mode, 0);

    // R2: unarmed, activity and idle time give nothing
    pulse_act(t);
    idle(3 * L);
    chk("R2 no request before USB reset", exp_q.size() == 0, exp_q.size(), 0);

    // R2: bus reset arms and starts the count
    pulse_urst(t);
    expect_ev(0, t + L + 3, "R2");
    idle(L + 10);

    // R3: no repeat without new activity
    idle(3 * L);

    // R1: plain activity pulse
    pulse_act(t);
    expect_ev(0, t + L + 3, "R1");
    idle(L + 10);

    // R4 restart, R8 activity while awake leaves lp_mode alone
    @(negedge clk); lp_set = 1'b1;
    @(negedge clk); lp_set = 1'b0;
    chk("R7 lp_set sets lp_mode", lp_mode == 1'b1, lp_mode, 1);
    pulse_act(t);
    idle(20);
    pulse_act(t2);
    expect_ev(0, t2 + L + 3, "R4");
    idle(L + 10);
    chk("R8 lp_mode kept while awake", lp_mode == 1'b1, lp_mode, 1);
    chk("R8 wake_line low while awake", wake_line == 1'b0, wake_line, 0);

    // R5: suspension during a running count suppresses the request
    pulse_urst(t);
    idle(10);
    @(negedge clk); force_susp = 1'b1;
    idle(2 * L);
    chk("R5 no request while suspended", exp_q.size() == 0, exp_q.size(), 0);

    // R6/R7 wakeup
    @(negedge clk); w = cyc; bus_act = 1'b1;
    @(negedge clk); bus_act = 1'b0;
    chk("R7 lp_mode before sync", lp_mode == 1'b1, lp_mode, 1);
    expect_ev(1, w + 3, "R6");
    @(negedge clk);
    chk("R7 lp_mode cleared after second edge", lp_mode == 1'b0, lp_mode, 0);
    chk("R6 wake_line not yet", wake_line == 1'b0, wake_line, 0);
    @(negedge clk);
    chk("R6 wake_line raised", wake_line == 1'b1, wake_line, 1);
    idle(10);

    // R9: further activity while suspended
    pulse_act(t);
    idle(10);
    chk("R9 wake_line held", wake_line == 1'b1, wake_line, 1);
    chk("R7 lp_mode stays low", lp_mode == 1'b0, lp_mode, 0);

    // R5/R6 resume end
    force_susp = 1'b0;
    idle(5);
    @(negedge clk); m = cyc; resume_done = 1'b1;
    @(negedge clk); resume_done = 1'b0;
    chk("R6 wake_line cleared by resume_done", wake_line == 1'b0, wake_line, 0);
    expect_ev(0, m + 1 + L, "R5");
    idle(L + 10);

    chk("R1-R9 queue drained", exp_q.size() == 0, exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule